// File: doc/BRIEF.md
# Symmetric PWM Timer Channel

This block is one channel of a timer that drives a centre-aligned pulse-width waveform on a single pin. An 8-bit counter advances one step for each timer-clock enable pulse. It rises from zero to the all-ones value and falls back again, so one waveform period spans 510 enable pulses. The output pin toggles where the counter crosses a compare threshold. Because the count is symmetric, the pulse stays centred in each period whatever the duty cycle.

Software writes the threshold into a holding register. Reads return that register, so a read always shows the last value written. The threshold that actually drives the waveform is copied from the holding register only when the counter arrives at its peak. A change of duty cycle therefore never produces a runt pulse.

A two-bit mode input either disconnects the pin or selects true or inverted polarity. The two extreme threshold values pin the output to a constant level. An overflow flag marks each start of a period, and a compare flag marks each threshold crossing. Each flag is cleared by a write-one pulse or by an interrupt acknowledge. Each flag raises its interrupt request only when its own enable and the global enable are both set.

Top module: `pwm_sym_channel`

## Requirements
- R1: With `tick` high, `count` follows 0,1,…,255,254,…,1,0,1,… starting from 0 after reset, so the sequence repeats every 510 ticks.
- R2: `ovf_flag` becomes 1 on the tick that moves `count` up out of 0x00.
- R3: `cmp_rdata` returns the value of the most recent `cmp_wr` from the cycle after that write on, whether or not that value is already driving the waveform.
- R4: The threshold in force is replaced by the holding register only on the tick that takes `count` from 0xFE to 0xFF. Until then the waveform follows the previous threshold.
- R5: In mode 2'b10 with a threshold C in 1..254, `pwm_out` is cleared when the counter steps up onto C and set when it steps down onto C. It is also cleared on reaching 0xFF and set on reaching 0x00, so the output is high while a rising count is below C and while a falling count is at or below C.
- R6: In mode 2'b11 with a threshold in 1..254, `pwm_out` is the complement of the R5 level.
- R7: A threshold of 0x00 holds `pwm_out` low in mode 2'b10 and high in mode 2'b11. A threshold of 0xFF holds it high in mode 2'b10 and low in mode 2'b11.
- R8: In modes 2'b00 and 2'b01, `pwm_out` is 0.
- R9: `cmp_flag` becomes 1 on any tick whose new count equals the threshold that was in force before that tick.
- R10: `ovf_irq` = `ovf_flag` & `ovf_ie` & `glob_ie`, and `cmp_irq` = `cmp_flag` & `cmp_ie` & `glob_ie`.
- R11: A pulse on `ovf_clr`/`ovf_ack` clears `ovf_flag`, and a pulse on `cmp_clr`/`cmp_ack` clears `cmp_flag`, at the next edge. If a set event occurs in the same cycle, the flag stays 1.
- R12: In a cycle with `tick` low, `count`, the threshold in force and `pwm_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| tick | input | 1 | timer-clock enable, one counter step per pulse |
| cmp_wr | input | 1 | write strobe for the threshold holding register |
| cmp_wdata | input | 8 | threshold write data |
| cmp_rdata | output | 8 | threshold read data (holding register) |
| count | output | 8 | current counter value |
| out_mode | input | 2 | 00/01 disconnected, 10 true polarity, 11 inverted |
| pwm_out | output | 1 | waveform pin |
| ovf_flag | output | 1 | period-start flag |
| cmp_flag | output | 1 | threshold-crossing flag |
| ovf_clr | input | 1 | write-one clear of the overflow flag |
| cmp_clr | input | 1 | write-one clear of the compare flag |
| ovf_ack | input | 1 | overflow interrupt acknowledge |
| cmp_ack | input | 1 | compare interrupt acknowledge |
| ovf_ie | input | 1 | overflow interrupt enable |
| cmp_ie | input | 1 | compare interrupt enable |
| glob_ie | input | 1 | global interrupt enable |
| ovf_irq | output | 1 | overflow interrupt request |
| cmp_irq | output | 1 | compare interrupt request |

## Verification
The assertions assume a few things about the inputs. Reset is held for at least two clock edges before any check applies. `out_mode` and `cmp_wr` are the only inputs that may change the pin or the holding register outside a tick. No output change is expected in a cycle with neither a tick nor a mode change. The stimulus issues writes, mode changes and most flag clears in cycles with `tick` low, so that these assumptions hold. Clears are combined with a tick only on purpose, to exercise the rule that a set event wins over a clear in the same cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        MODE_OFF_A  = 2'b00,
        MODE_OFF_B  = 2'b01,
        MODE_TRUE   = 2'b10,
        MODE_INVERT = 2'b11
    } pwm_mode_e;

    // one counter step, described by what it reaches
    typedef struct packed {
        logic tick;         // a step happens this cycle
        logic step_up;      // the step increments the count
        logic leave_bottom; // step out of zero
        logic reach_top;    // step onto the all-ones value
        logic reach_bottom; // step onto zero
    } step_evt_t;

    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned FLAG_OVF  = 0;
    localparam int unsigned FLAG_CMP  = 1;

    // connected modes drive the pin, bit 0 selects inversion
    function automatic logic mode_connected(input pwm_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_inverted(input pwm_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [WIDTH-1:0] cnt_q,
    output logic [WIDTH-1:0] cnt_nx,
    output step_evt_t        evt
);
    localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic up_q, up_nx;

    always_comb begin
        if (up_q) begin
            if (cnt_q == TOP) begin
                cnt_nx = TOP - ONE;
                up_nx  = 1'b0;
            end else begin
                cnt_nx = cnt_q + ONE;
                up_nx  = 1'b1;
            end
        end else begin
            if (cnt_q == ZERO) begin
                cnt_nx = ONE;
                up_nx  = 1'b1;
            end else begin
                cnt_nx = cnt_q - ONE;
                up_nx  = 1'b0;
            end
        end
    end

    always_comb begin
        evt.tick         = tick;
        evt.step_up      = (up_q && cnt_q != TOP) || (!up_q && cnt_q == ZERO);
        evt.leave_bottom = tick && (cnt_q == ZERO);
        evt.reach_top    = tick && (cnt_nx == TOP);
        evt.reach_bottom = tick && (cnt_nx == ZERO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
            up_q  <= 1'b1;
        end else if (tick) begin
            cnt_q <= cnt_nx;
            up_q  <= up_nx;
        end
    end

    // R1: every tick moves the count by exactly one
    p_unit_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick)) |->
            (cnt_q == WIDTH'($past(cnt_q) + ONE)) || (cnt_q == WIDTH'($past(cnt_q) - ONE)));

    // R12: no tick, no movement
    p_count_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |-> $stable(cnt_q));

endmodule

// File: rtl/pwm_cmp_buffer.sv
module pwm_cmp_buffer #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             load,
    output logic [WIDTH-1:0] hold_q,
    output logic [WIDTH-1:0] active_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            active_q <= '0;
        end else begin
            if (wr_en) hold_q   <= wr_data;
            if (load)  active_q <= hold_q;
        end
    end

    // R4: the threshold in force moves only at the counter peak
    p_latch_at_peak_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && active_q != $past(active_q)) |-> $past(load));

    // R3: a write is visible on the next cycle
    p_readback_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> hold_q == $past(wr_data));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
    import pwm_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  step_evt_t        evt,
    input  logic [WIDTH-1:0] cnt_nx,
    input  logic [WIDTH-1:0] active,
    input  pwm_mode_e        mode,
    output logic             match,
    output logic             pwm_o
);
    localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic level_q;   // true-polarity level
    logic forced;

    assign match  = evt.tick && (cnt_nx == active);
    assign forced = (active == ZERO) || (active == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b1;
        end else if (evt.reach_top) begin
            level_q <= 1'b0;
        end else if (evt.reach_bottom) begin
            level_q <= 1'b1;
        end else if (match) begin
            level_q <= !evt.step_up;
        end
    end

    always_comb begin
        if (!mode_connected(mode)) begin
            pwm_o = 1'b0;
        end else if (forced) begin
            pwm_o = (active == TOP) ^ mode_inverted(mode);
        end else begin
            pwm_o = level_q ^ mode_inverted(mode);
        end
    end

    // R5: the pin moves only on a counter step or a mode change
    p_no_stray_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(pwm_o)) |-> ($past(evt.tick) || !$stable(mode)));

    // R8: a disconnected pin stays low across every step
    p_off_stays_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !mode[1] && !$past(mode[1])) |-> (!pwm_o && !$past(pwm_o)));

endmodule

// File: rtl/pwm_flags.sv
module pwm_flags
    import pwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] set_evt,
    input  logic [NUM_FLAGS-1:0] clr_w1c,
    input  logic [NUM_FLAGS-1:0] ack,
    input  logic [NUM_FLAGS-1:0] ie,
    input  logic                 gie,
    output logic [NUM_FLAGS-1:0] flag_q,
    output logic [NUM_FLAGS-1:0] irq
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
            end else if (set_evt[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_w1c[i] || ack[i]) begin
                flag_q[i] <= 1'b0;
            end
        end

        assign irq[i] = flag_q[i] && ie[i] && gie;

        // R2 (overflow) and R9 (compare): a set event always lands
        p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(set_evt[i])) |-> flag_q[i]);

        // R11: a clear without a competing set empties the flag
        p_flag_clear_r11: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past((clr_w1c[i] || ack[i]) && !set_evt[i])) |-> !flag_q[i]);
    end

endmodule

// File: rtl/pwm_sym_channel.sv
module pwm_sym_channel
    import pwm_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cmp_wr,
    input  logic [WIDTH-1:0] cmp_wdata,
    output logic [WIDTH-1:0] cmp_rdata,
    output logic [WIDTH-1:0] count,
    input  logic [1:0]       out_mode,
    output logic             pwm_out,
    output logic             ovf_flag,
    output logic             cmp_flag,
    input  logic             ovf_clr,
    input  logic             cmp_clr,
    input  logic             ovf_ack,
    input  logic             cmp_ack,
    input  logic             ovf_ie,
    input  logic             cmp_ie,
    input  logic             glob_ie,
    output logic             ovf_irq,
    output logic             cmp_irq
);
    logic [WIDTH-1:0]     cnt_nx;
    logic [WIDTH-1:0]     active;
    step_evt_t            evt;
    logic                 match;
    logic [NUM_FLAGS-1:0] set_evt, clr_w1c, ack_v, ie_v, flag_v, irq_v;

    pwm_counter #(.WIDTH(WIDTH)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .cnt_q  (count),
        .cnt_nx (cnt_nx),
        .evt    (evt)
    );

    pwm_cmp_buffer #(.WIDTH(WIDTH)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cmp_wr),
        .wr_data  (cmp_wdata),
        .load     (evt.reach_top),
        .hold_q   (cmp_rdata),
        .active_q (active)
    );

    pwm_wave #(.WIDTH(WIDTH)) u_wave (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .cnt_nx (cnt_nx),
        .active (active),
        .mode   (pwm_mode_e'(out_mode)),
        .match  (match),
        .pwm_o  (pwm_out)
    );

    always_comb begin
        set_evt[FLAG_OVF] = evt.leave_bottom;
        set_evt[FLAG_CMP] = match;
        clr_w1c[FLAG_OVF] = ovf_clr;
        clr_w1c[FLAG_CMP] = cmp_clr;
        ack_v[FLAG_OVF]   = ovf_ack;
        ack_v[FLAG_CMP]   = cmp_ack;
        ie_v[FLAG_OVF]    = ovf_ie;
        ie_v[FLAG_CMP]    = cmp_ie;
    end

    pwm_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_evt),
        .clr_w1c (clr_w1c),
        .ack     (ack_v),
        .ie      (ie_v),
        .gie     (glob_ie),
        .flag_q  (flag_v),
        .irq     (irq_v)
    );

    assign ovf_flag = flag_v[FLAG_OVF];
    assign cmp_flag = flag_v[FLAG_CMP];
    assign ovf_irq  = irq_v[FLAG_OVF];
    assign cmp_irq  = irq_v[FLAG_CMP];

    // R10: a request never appears with the global enable low
    p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf_irq || cmp_irq) |-> glob_ie);

endmodule

// File: tb/test_pwm_sym_channel.sv
module test_pwm_sym_channel;
    localparam int W      = 8;
    localparam int PERIOD = 510;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic [W-1:0] cmp_rdata, count;
    logic [1:0] out_mode = 2'b00;
    logic pwm_out, ovf_flag, cmp_flag, ovf_irq, cmp_irq;
    logic ovf_clr = 0, cmp_clr = 0, ovf_ack = 0, cmp_ack = 0;
    logic ovf_ie = 0, cmp_ie = 0, glob_ie = 0;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model
    int t_m = 0;
    int hold_m = 0, active_m = 0;
    bit ovf_m = 0, cmp_m = 0;

    always #5 clk = ~clk;

    pwm_sym_channel #(.WIDTH(W)) i_pwm_sym_channel (
        .clk(clk), .rst(rst), .tick(tick), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .cmp_rdata(cmp_rdata), .count(count), .out_mode(out_mode), .pwm_out(pwm_out),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
        .ovf_ack(ovf_ack), .cmp_ack(cmp_ack), .ovf_ie(ovf_ie), .cmp_ie(cmp_ie),
        .glob_ie(glob_ie), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t_m, act, exp);
        end
    endtask

    function automatic int cnt_of(input int t);
        int p = t % PERIOD;
        return (p <= 255) ? p : PERIOD - p;
    endfunction

    function automatic bit rising_of(input int t);
        return (t % PERIOD) <= 255;
    endfunction

    function automatic int exp_pwm();
        int c = cnt_of(t_m);
        bit lvl;
        if (out_mode[1] == 1'b0) return 0;
        if (active_m == 0)   return out_mode[0];
        if (active_m == 255) return !out_mode[0];
        lvl = rising_of(t_m) ? (c < active_m) : (c <= active_m);
        return lvl ^ out_mode[0];
    endfunction

    function automatic string pwm_req();
        if (hold_m != active_m) return "R4";
        if (out_mode[1] == 1'b0) return "R8";
        if (active_m == 0 || active_m == 255) return "R7";
        return out_mode[0] ? "R6" : "R5";
    endfunction

    task automatic check_all(input string flag_req);
        chk("R1 count", count, cnt_of(t_m));
        chk(pwm_req(), pwm_out, exp_pwm());
        chk({flag_req, " ovf"}, ovf_flag, ovf_m);
        chk("R9 cmp", cmp_flag, cmp_m);
        chk("R10 ovf_irq", ovf_irq, ovf_m & ovf_ie & glob_ie);
        chk("R10 cmp_irq", cmp_irq, cmp_m & cmp_ie & glob_ie);
    endtask

    task automatic do_tick(input bit with_clr);
        int old_c = cnt_of(t_m);
        int new_c = cnt_of(t_m + 1);
        bit s_ovf = (old_c == 0);
        bit s_cmp = (new_c == active_m);
        ovf_ie  = t_m[3];
        cmp_ie  = t_m[4];
        glob_ie = t_m[5] | t_m[6];
        tick    = 1'b1;
        ovf_clr = with_clr;
        @(posedge clk);
        @(negedge clk);
        tick    = 1'b0;
        ovf_clr = 1'b0;
        t_m++;
        if (new_c == 255 && rising_of(t_m)) active_m = hold_m;
        ovf_m = s_ovf ? 1'b1 : (with_clr ? 1'b0 : ovf_m);
        cmp_m = s_cmp ? 1'b1 : cmp_m;
        check_all(with_clr ? "R11" : "R2");
    endtask

    task automatic write_cmp(input int v);
        int c0 = count;
        cmp_wr    = 1'b1;
        cmp_wdata = W'(v);
        @(posedge clk);
        @(negedge clk);
        cmp_wr = 1'b0;
        hold_m = v;
        chk("R3 readback", cmp_rdata, v);
        chk("R12 no tick", count, c0);
        chk(pwm_req(), pwm_out, exp_pwm());
    endtask

    task automatic clear_cycle(input int sel);
        case (sel % 4)
            0: ovf_clr = 1'b1;
            1: ovf_ack = 1'b1;
            2: cmp_clr = 1'b1;
            default: cmp_ack = 1'b1;
        endcase
        @(posedge clk);
        @(negedge clk);
        ovf_clr = 0; ovf_ack = 0; cmp_clr = 0; cmp_ack = 0;
        if (sel % 4 < 2) ovf_m = 1'b0; else cmp_m = 1'b0;
        check_all("R11");
        chk("R12 hold", count, cnt_of(t_m));
    endtask

    function automatic int cval(input int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 127;
            4: return 253;
            5: return 254;
            default: return 255;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state
        chk("R1 reset count", count, 0);
        chk("R8 reset pin", pwm_out, 0);
        chk("R2 reset ovf", ovf_flag, 0);
        chk("R9 reset cmp", cmp_flag, 0);
        chk("R3 reset read", cmp_rdata, 0);
        for (int m = 0; m < 4; m++) begin
            int mm = (m + 2) % 4;   // true, inverted, then disconnected modes
            out_mode = 2'(mm);
            @(posedge clk);
            @(negedge clk);
            check_all("R2");
            for (int ci = 0; ci < 7; ci++) begin
                write_cmp(cval(ci));
                write_cmp(cval((ci + 3) % 7));  // overwritten before the peak
                write_cmp(cval(ci));
                for (int k = 0; k < PERIOD + 13; k++) begin
                    do_tick((k % 101) == 0);
                    if ((k % 23) == 7) clear_cycle(k / 23);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule